// File: doc/BRIEF.md
# Overflow-Counting Timer with Event Capture

A 32-bit general-purpose timer driven from one control word, a load register and a read-only capture register. The counter runs up or down. It either wraps across its full range (free-running) or restarts every period set by the load register (periodic). Each count step is gated by a tick enable taken from one of four sources: the core clock, a low-rate tick input, or a rising edge on one of two external pins. The external pins are synchronised inside the block.

An 8-bit postscaler counts timer overflows, so the interrupt can be held back until a programmed number of periods has elapsed. Software picks whether the interrupt follows every overflow or only each postscaler match. The interrupt request and the match flag stay set until a clear strobe arrives.

A capture unit watches one of 32 event lines, chosen by a field in the control word. When that line is high at a clock edge, it copies the running count into the capture register.

Top module: `cap_timer`

## Requirements
- R1: After reset, `ctrl_rd` reads 0x01000000, and `count`, `load_rd`, `capture` and `irq` all read 0.
- R2: Control bits [11:9] choose the tick source. 000 steps on every cycle. 001 steps on cycles where `lp_tick` is high. 010 and 011 step once per rising edge of `ext_pin[0]` and `ext_pin[1]`, seen through a two-stage synchroniser. Every other code never steps.
- R3: With bit 8 clear the count decrements on each step. At 0 an overflow occurs. The next value is 0xFFFFFFFF when bit 6 is clear, and the load value when bit 6 is set.
- R4: With bit 8 set the count increments on each step. The limit is 0xFFFFFFFF when bit 6 is clear, and the load value when bit 6 is set. At the limit an overflow occurs and the count restarts at 0.
- R5: Bit 7 enables stepping, and while it is clear the count holds. A `wr_load` while bit 7 is clear writes both the load register and the counter. While bit 7 is set, `wr_load` writes only the load register.
- R6: With bit 18 clear, every overflow sets `irq`. `irq` stays high until `clr_irq`. When a set and `clr_irq` land in the same cycle, the set wins.
- R7: Bits [31:24] are written as the postscaler target, and a target of 0 acts as 1. Bit 23 enables the postscaler. Reading bits [31:24] returns the live period number. The live number starts at 1, rises by one on each overflow, and returns to 1 on the overflow that equals the target. Any control write restarts it at 1.
- R8: Read-only bit 19 is set by a postscaler match and cleared by `clr_irq`. With bit 18 set, `irq` is set only by a postscaler match.
- R9: With bit 17 set, if `events[sel]` is high at a clock edge, `capture` takes the count held before that edge. `sel` is control bits [16:12]. Otherwise `capture` holds.
- R10: Control read bits [22:20] and [5:0] always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_ctrl | input | 1 | Write strobe for the control word |
| wr_load | input | 1 | Write strobe for the load register |
| wdata | input | 32 | Write data for both registers |
| clr_irq | input | 1 | Clears the interrupt request and the match flag |
| lp_tick | input | 1 | Low-rate tick enable (source code 001) |
| ext_pin | input | 2 | Asynchronous external count pins |
| events | input | 32 | Capture event lines |
| ctrl_rd | output | 32 | Control word readback with live postscaler count and flag |
| load_rd | output | 32 | Load register readback |
| count | output | 32 | Running count |
| capture | output | 32 | Captured count |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets several boundaries:
- The wrap at zero and at all-ones. A wrong next value there gives a period off by one or a count that sticks.
- An up-counting periodic start that begins exactly at the load value. It must overflow on the first step, not after a full wrap.
- A postscaler target of 0. A design that takes 0 literally never matches, and so never raises the match flag or the interrupt.
- A clear strobe held across cycles where an overflow arrives. A design that lets the clear win loses interrupts.
- Pin ticks. A missing synchroniser stage shifts every step by one cycle, and level sensing instead of edge sensing steps on every high cycle.
- Capture. Taking the count after the edge instead of before it, or from a line other than the selected one, shows up at once against the reference model.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

  localparam int unsigned CTRL_W  = 32;
  localparam int unsigned POST_W  = 8;
  localparam int unsigned EV_N    = 32;
  localparam int unsigned EV_SELW = $clog2(EV_N);
  localparam int unsigned PIN_N   = 2;

  localparam logic [2:0] SRC_CORE = 3'd0;
  localparam logic [2:0] SRC_LP   = 3'd1;
  localparam logic [2:0] SRC_PIN0 = 3'd2;
  localparam logic [2:0] SRC_PIN1 = 3'd3;

  typedef struct packed {
    logic [POST_W-1:0]  post_tgt;
    logic               post_en;
    logic               irq_src;
    logic               cap_en;
    logic [EV_SELW-1:0] ev_sel;
    logic [2:0]         clk_sel;
    logic               up;
    logic               run;
    logic               periodic;
  } ctrl_t;

  function automatic logic [POST_W-1:0] post_effective(input logic [POST_W-1:0] tgt);
    return (tgt == '0) ? POST_W'(1) : tgt;
  endfunction

endpackage

// File: rtl/cap_timer_sync.sv
module cap_timer_sync #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [2:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[1:0], pin_i[g]};
    end
    // sh[1] is the synchronised level, sh[2] its previous value
    assign rise_o[g] = sh[1] & ~sh[2];
  end
endmodule

// File: rtl/cap_timer_count.sv
module cap_timer_count #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         run_i,
  input  logic         up_i,
  input  logic         periodic_i,
  input  logic         load_wr_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] load_o,
  output logic [W-1:0] count_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q, load_q;

  function automatic logic hit_limit(input logic [W-1:0] c, input logic [W-1:0] ld,
                                     input logic up, input logic per);
    if (up) return c == (per ? ld : {W{1'b1}});
    return c == '0;
  endfunction

  function automatic logic [W-1:0] next_count(input logic [W-1:0] c, input logic [W-1:0] ld,
                                              input logic up, input logic per);
    if (hit_limit(c, ld, up, per)) return up ? '0 : (per ? ld : {W{1'b1}});
    return up ? c + 1'b1 : c - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      load_q <= '0;
    end else begin
      if (load_wr_i) load_q <= load_val_i;
      if (load_wr_i && !run_i) cnt_q <= load_val_i;
      else if (step_i)         cnt_q <= next_count(cnt_q, load_q, up_i, periodic_i);
    end
  end

  assign ovf_o   = step_i & hit_limit(cnt_q, load_q, up_i, periodic_i);
  assign count_o = cnt_q;
  assign load_o  = load_q;
endmodule

// File: rtl/cap_timer_post.sv
module cap_timer_post
  import cap_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic              en_i,
  input  logic              ovf_i,
  input  logic [POST_W-1:0] target_i,
  output logic [POST_W-1:0] live_o,
  output logic              match_o
);
  localparam logic [POST_W-1:0] FIRST = POST_W'(1);
  logic [POST_W-1:0] live_q;

  assign match_o = en_i & ovf_i & (live_q == post_effective(target_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             live_q <= FIRST;
    else if (restart_i)     live_q <= FIRST;
    else if (en_i && ovf_i) live_q <= match_o ? FIRST : live_q + 1'b1;
  end

  assign live_o = live_q;
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int unsigned TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_load,
  input  logic [31:0]   wdata,
  input  logic          clr_irq,
  input  logic          lp_tick,
  input  logic [1:0]    ext_pin,
  input  logic [31:0]   events,
  output logic [31:0]   ctrl_rd,
  output logic [TW-1:0] load_rd,
  output logic [TW-1:0] count,
  output logic [TW-1:0] capture,
  output logic          irq
);
  ctrl_t             ctrl_q;
  logic              flag_q, irq_q;
  logic [TW-1:0]     cap_q;
  logic [PIN_N-1:0]  pin_rise;
  logic              tick, step, ovf, post_match, irq_set, cap_hit;
  logic [POST_W-1:0] post_live;
  logic              unused_wbits;

  assign unused_wbits = ^{wdata[22:19], wdata[5:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q          <= '0;
      ctrl_q.post_tgt <= POST_W'(1);
    end else if (wr_ctrl) begin
      ctrl_q <= '{post_tgt: wdata[31:24], post_en: wdata[23], irq_src: wdata[18],
                  cap_en: wdata[17], ev_sel: wdata[16:12], clk_sel: wdata[11:9],
                  up: wdata[8], run: wdata[7], periodic: wdata[6]};
    end
  end

  cap_timer_sync #(.N(PIN_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_pin), .rise_o(pin_rise)
  );

  always_comb begin
    unique case (ctrl_q.clk_sel)
      SRC_CORE: tick = 1'b1;
      SRC_LP:   tick = lp_tick;
      SRC_PIN0: tick = pin_rise[0];
      SRC_PIN1: tick = pin_rise[1];
      default:  tick = 1'b0;
    endcase
  end
  assign step = ctrl_q.run & tick;

  cap_timer_count #(.W(TW)) u_count (
    .clk(clk), .rst_n(rst_n), .step_i(step), .run_i(ctrl_q.run), .up_i(ctrl_q.up),
    .periodic_i(ctrl_q.periodic), .load_wr_i(wr_load), .load_val_i(wdata[TW-1:0]),
    .load_o(load_rd), .count_o(count), .ovf_o(ovf)
  );

  cap_timer_post u_post (
    .clk(clk), .rst_n(rst_n), .restart_i(wr_ctrl), .en_i(ctrl_q.post_en), .ovf_i(ovf),
    .target_i(ctrl_q.post_tgt), .live_o(post_live), .match_o(post_match)
  );

  assign irq_set = ctrl_q.irq_src ? post_match : ovf;
  assign cap_hit = ctrl_q.cap_en & events[ctrl_q.ev_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      cap_q  <= '0;
    end else begin
      if (post_match)   flag_q <= 1'b1;
      else if (clr_irq) flag_q <= 1'b0;
      if (irq_set)      irq_q  <= 1'b1;
      else if (clr_irq) irq_q  <= 1'b0;
      if (cap_hit)      cap_q  <= count;
    end
  end

  assign ctrl_rd = {post_live, ctrl_q.post_en, 3'b000, flag_q, ctrl_q.irq_src, ctrl_q.cap_en,
                    ctrl_q.ev_sel, ctrl_q.clk_sel, ctrl_q.up, ctrl_q.run, ctrl_q.periodic, 6'b0};
  assign capture = cap_q;
  assign irq     = irq_q;
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
  parameter int unsigned TW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_load,
  input logic          clr_irq,
  input logic          run,
  input logic          up,
  input logic          periodic,
  input logic          irq_src,
  input logic          cap_en,
  input logic [4:0]    ev_sel,
  input logic [31:0]   events,
  input logic          ovf,
  input logic          post_match,
  input logic          flag,
  input logic [7:0]    post_live,
  input logic [TW-1:0] count,
  input logic [TW-1:0] capture,
  input logic          irq
);
  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_load) |=> $stable(count)); // R5
  AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !up && !periodic) |=> (count == {TW{1'b1}})); // R3
  AST_UP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && up) |=> (count == '0)); // R4
  AST_OVF_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !irq_src) |=> irq); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_irq) |=> irq); // R6
  AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    post_match |=> flag); // R8
  AST_LIVE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    post_live != 8'd0); // R7
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_en && events[ev_sel]) |=> $stable(capture)); // R9
endmodule

bind cap_timer cap_timer_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_load(wr_load), .clr_irq(clr_irq),
  .run(ctrl_q.run), .up(ctrl_q.up), .periodic(ctrl_q.periodic), .irq_src(ctrl_q.irq_src),
  .cap_en(ctrl_q.cap_en), .ev_sel(ctrl_q.ev_sel), .events(events), .ovf(ovf),
  .post_match(post_match), .flag(flag_q), .post_live(post_live), .count(count),
  .capture(capture), .irq(irq)
);

// File: tb/tb_cap_timer.sv
module tb_cap_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_ctrl = 1'b0, wr_load = 1'b0, clr_irq = 1'b0;
  logic [31:0] wdata = '0;
  logic        lp_tick = 1'b0;
  logic [1:0]  ext_pin = '0;
  logic [31:0] events = '0;
  logic [31:0] ctrl_rd, load_rd, count, capture;
  logic        irq;

  int tests = 0, fails = 0;
  bit done = 0, checking = 0, rnd_on = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  cap_timer dut (.*);

  // ---------- behavioural reference ----------
  logic [31:0] m_cnt, m_load, m_cap, m_cw, old_cnt, lim;
  int          m_pc, tgt;
  bit          m_flag, m_irq, tk, stp, ov, mt;
  logic [1:0]  h1, h2, h3, rise;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_load = 0; m_cap = 0; m_cw = 32'h0100_0000; m_pc = 1;
      m_flag = 0; m_irq = 0; h1 = 0; h2 = 0; h3 = 0;
    end else begin
      rise = h2 & ~h3;
      case (m_cw[11:9])
        3'd0: tk = 1;
        3'd1: tk = lp_tick;
        3'd2: tk = rise[0];
        3'd3: tk = rise[1];
        default: tk = 0;
      endcase
      h3 = h2; h2 = h1; h1 = ext_pin;
      stp = m_cw[7] && tk;
      old_cnt = m_cnt;
      ov = 0;
      if (stp) begin
        if (m_cw[8]) begin
          lim = m_cw[6] ? m_load : 32'hFFFF_FFFF;
          if (m_cnt == lim) begin ov = 1; m_cnt = 0; end
          else m_cnt = m_cnt + 1;
        end else if (m_cnt == 0) begin
          ov = 1; m_cnt = m_cw[6] ? m_load : 32'hFFFF_FFFF;
        end else m_cnt = m_cnt - 1;
      end
      if (wr_load) begin m_load = wdata; if (!m_cw[7]) m_cnt = wdata; end
      tgt = (m_cw[31:24] == 0) ? 1 : int'(m_cw[31:24]);
      mt = 0;
      if (ov && m_cw[23]) begin
        if (m_pc == tgt) begin mt = 1; m_pc = 1; end else m_pc++;
      end
      if (m_cw[17] && events[m_cw[16:12]]) m_cap = old_cnt;
      if (mt) m_flag = 1; else if (clr_irq) m_flag = 0;
      if (m_cw[18] ? mt : ov) m_irq = 1; else if (clr_irq) m_irq = 0;
      if (wr_ctrl) begin m_cw = wdata; m_pc = 1; end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) if (checking) begin
    chk(cur_req, count, m_cnt);
    chk(cur_req, {31'b0, irq}, {31'b0, m_irq});
    chk("R7", ctrl_rd, {m_pc[7:0], m_cw[23], 3'b000, m_flag, m_cw[18:6], 6'b0});
    chk("R9", capture, m_cap);
    chk("R10", ctrl_rd & 32'h0070_003F, 32'h0);
    chk("R5", load_rd, m_load);
  end

  // random side inputs
  always @(negedge clk) begin
    if (rnd_on) begin
      lp_tick = ($urandom % 3) == 0;
      if (($urandom % 4) == 0) ext_pin[0] = ~ext_pin[0];
      if (($urandom % 5) == 0) ext_pin[1] = ~ext_pin[1];
      events  = (($urandom % 4) == 0) ? (32'h1 << ($urandom % 32)) : 32'h0;
    end else begin
      lp_tick = 0; events = 0;
    end
  end

  function automatic logic [31:0] mk(input logic [7:0] pt, input bit pen, input bit src,
      input bit cap, input logic [4:0] sel, input logic [2:0] cs, input bit up,
      input bit en, input bit per);
    return {pt, pen, 3'b000, 1'b0, src, cap, sel, cs, up, en, per, 6'b0};
  endfunction

  task automatic wctrl(input logic [31:0] v);
    @(negedge clk); wdata = v; wr_ctrl = 1;
    @(negedge clk); wr_ctrl = 0;
  endtask
  task automatic wload(input logic [31:0] v);
    @(negedge clk); wdata = v; wr_load = 1;
    @(negedge clk); wr_load = 0;
  endtask
  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic clr(input int n);
    @(negedge clk); clr_irq = 1;
    repeat (n) @(negedge clk);
    clr_irq = 0;
  endtask

  initial begin
    run(3);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", ctrl_rd, 32'h0100_0000);
    chk("R1", count, 0);
    chk("R1", capture, 0);
    chk("R1", load_rd, 0);
    chk("R1", {31'b0, irq}, 0);
    checking = 1;

    cur_req = "R5"; wload(10); run(4);
    cur_req = "R3"; wctrl(mk(1, 0, 0, 0, 0, 3'd0, 0, 1, 1)); run(30); clr(1); run(5);
    wctrl(mk(1, 0, 0, 0, 0, 3'd0, 0, 0, 0)); wload(2);
    wctrl(mk(1, 0, 0, 0, 0, 3'd0, 0, 1, 0)); run(8);
    cur_req = "R4"; wctrl(mk(1, 0, 0, 0, 0, 3'd0, 1, 0, 1)); wload(4);
    wctrl(mk(1, 0, 0, 0, 0, 3'd0, 1, 1, 1)); run(20);
    cur_req = "R5"; wload(7); run(20);
    cur_req = "R4"; wctrl(mk(1, 0, 0, 0, 0, 3'd0, 1, 0, 0)); wload(32'hFFFF_FFFD);
    wctrl(mk(1, 0, 0, 0, 0, 3'd0, 1, 1, 0)); run(8);
    cur_req = "R7"; wctrl(mk(1, 0, 0, 0, 0, 3'd0, 0, 0, 1)); wload(3); clr(1);
    wctrl(mk(3, 1, 1, 0, 0, 3'd0, 0, 1, 1)); run(30);
    cur_req = "R8"; clr(1); run(20); clr(1);
    wctrl(mk(0, 1, 1, 0, 0, 3'd0, 0, 1, 1)); run(20);
    cur_req = "R6"; wctrl(mk(0, 0, 0, 0, 0, 3'd0, 0, 0, 1)); wload(1);
    wctrl(mk(0, 0, 0, 0, 0, 3'd0, 0, 1, 1)); clr(10); run(3);
    cur_req = "R2"; rnd_on = 1; wload(5);
    wctrl(mk(2, 1, 0, 0, 0, 3'd1, 0, 1, 1)); run(60);
    wctrl(mk(2, 1, 0, 0, 0, 3'd2, 1, 1, 0)); run(80);
    wctrl(mk(2, 1, 0, 0, 0, 3'd3, 0, 1, 0)); run(80);
    wctrl(mk(2, 1, 0, 0, 0, 3'd5, 0, 1, 0)); run(30);
    cur_req = "R9"; wctrl(mk(1, 0, 0, 1, 5'd7, 3'd0, 0, 1, 0)); run(120);
    wctrl(mk(1, 0, 0, 1, 5'd31, 3'd0, 1, 1, 0)); run(120);
    wctrl(mk(1, 0, 0, 0, 5'd7, 3'd0, 1, 1, 0)); run(40);
    rnd_on = 0; run(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule